// File: doc/BRIEF.md
# Parity-Checked Serial Register Access Port

This block is a slave port that gives a local processor read and write access to a small bank of 32-bit configuration registers over four wires. Those wires are a serial clock, an active-low select, serial data in and serial data out. While select is low, the port samples one instruction bit on each rising edge of the serial clock. An instruction is 41 bits long and holds an even-parity bit, a read/write opcode, a 7-bit register address and a 32-bit data word. When select returns high, the port checks the bit count and the parity. A well-formed instruction is carried out. A malformed one is dropped and changes nothing.

Every executed instruction also loads a 41-bit response frame. The response has the same layout as an instruction and carries its own parity bit. It is shifted out on serial data out during the next select window. This is how a read returns the register value and how a write echoes what was stored. All logic runs on the serial clock. Serial data out changes only on the falling edge, so the host can sample it on the rising edge. A synchronous active-high reset clears the shift register, the response frame and every implemented register.

Top module: `sreg_port`

## Requirements
- R1: While reset is high on a rising edge, every implemented register, the captured instruction and the response frame clear to zero, and serial data out is 0 from the next falling edge onward.
- R2: Bits are sampled on the rising edge with the first bit at frame position 0. Position 0 is parity, position 1 is the opcode, positions 2..8 are the address (LSB at 2) and positions 9..40 are the data (LSB at 9).
- R3: A frame of exactly 41 bits with even parity over all 41 bits and opcode 1 writes its data to the addressed register at the first rising edge after select goes high.
- R4: A 41-bit frame with odd parity over its 41 bits changes no register and leaves the response frame unchanged.
- R5: A frame of any length other than 41 bits (for example 40 or 42) is discarded. No register changes and the response is unchanged.
- R6: A valid frame with opcode 0 loads the response with opcode 0, the same address and the register contents. During the next select window that response is shifted out in the R2 layout, with position 0 set so the 41-bit response has even parity.
- R7: Only addresses 1..8 hold registers. Any other address reads as zero and ignores writes, and the response of such an instruction carries zero data.
- R8: After a valid write, the next response frame carries opcode 1, the written address and the stored value.
- R9: Serial data out changes only on falling edges of the serial clock and holds its value across rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; all port state is clocked by it |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial instruction input, sampled on rising edge |
| sdo | output | 1 | Serial response output, updated on falling edge |

## Verification
Execution of one instruction and the start of the next response can fall on neighbouring edges. At the single rising edge where select is high, the port commits the write and loads the response. At the falling edge that follows, position 0 of that new response must already appear on serial data out. The bench drives frames with only one idle clock between them, so each commit meets the next frame's first response bit. It judges the result by checking that every returned frame matches the previous instruction's address, opcode, data and even parity. It also samples serial data out on both sides of each rising edge to confirm the value holds there.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int FRAME_W = 41;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 32;
  localparam int CNT_W   = $clog2(FRAME_W + 2);

  // Packed from MSB down: position 0 (parity) is the first bit on the wire.
  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [ADDR_W-1:0] addr;
    logic              op;
    logic              par;
  } instr_t;
endpackage

// File: rtl/sreg_shifter.sv
module sreg_shifter
  import sreg_pkg::*;
(
  input  logic             sclk,
  input  logic             rst,
  input  logic             sel_n,
  input  logic             sdi,
  output logic [CNT_W-1:0] cnt,
  output logic             exec,
  output instr_t           instr
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] OVER = CNT_W'(FRAME_W + 1);

  logic [FRAME_W-1:0] shreg;
  logic               active;

  always_ff @(posedge sclk) begin
    if (rst) begin
      shreg  <= '0;
      cnt    <= '0;
      active <= 1'b0;
    end else if (!sel_n) begin
      shreg  <= {sdi, shreg[FRAME_W-1:1]};
      active <= 1'b1;
      if (cnt != OVER) cnt <= cnt + 1'b1;
    end else begin
      active <= 1'b0;
      cnt    <= '0;
    end
  end

  assign instr = instr_t'(shreg);
  assign exec  = active && sel_n && (cnt == FULL) && !(^shreg);
endmodule

// File: rtl/sreg_bank.sv
module sreg_bank
  import sreg_pkg::*;
#(
  parameter int NUM_REGS  = 8,
  parameter int BASE_ADDR = 1
) (
  input  logic                     sclk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  output logic                     hit,
  output logic [DATA_W-1:0]        rdata,
  output logic [DATA_W-1:0]        echo,
  output logic [NUM_REGS*DATA_W-1:0] flat
);
  localparam int IW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [ADDR_W:0] BASE_V = (ADDR_W+1)'(BASE_ADDR);
  localparam logic [ADDR_W:0] NUM_V  = (ADDR_W+1)'(NUM_REGS);

  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [ADDR_W:0]   off;
  logic [IW-1:0]     idx;

  assign off = {1'b0, addr} - BASE_V;
  assign hit = ({1'b0, addr} >= BASE_V) && (off < NUM_V);
  assign idx = off[IW-1:0];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge sclk) begin
      if (rst)                                 regs[g] <= '0;
      else if (wr_en && hit && idx == IW'(g))  regs[g] <= wdata;
    end
    assign flat[g*DATA_W +: DATA_W] = regs[g];
  end

  assign rdata = hit ? regs[idx] : '0;
  assign echo  = (wr_en && hit) ? wdata : rdata;
endmodule

// File: rtl/sreg_txframe.sv
module sreg_txframe
  import sreg_pkg::*;
(
  input  logic              sclk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              load,
  input  logic              op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic [FRAME_W-1:0] oframe,
  output logic              sdo
);
  instr_t nxt;
  logic   bit_sel;

  always_comb begin
    nxt.data = data;
    nxt.addr = addr;
    nxt.op   = op;
    nxt.par  = ^{data, addr, op};
  end

  always_ff @(posedge sclk) begin
    if (rst)       oframe <= '0;
    else if (load) oframe <= nxt;
  end

  always_comb begin
    if (sel_n)                      bit_sel = oframe[0];
    else if (cnt < CNT_W'(FRAME_W)) bit_sel = oframe[cnt];
    else                            bit_sel = 1'b0;
  end

  always_ff @(negedge sclk) begin
    if (rst) sdo <= 1'b0;
    else     sdo <= bit_sel;
  end
endmodule

// File: rtl/sreg_port.sv
module sreg_port
  import sreg_pkg::*;
#(
  parameter int NUM_REGS  = 8,
  parameter int BASE_ADDR = 1
) (
  input  logic sclk,
  input  logic rst,
  input  logic sel_n,
  input  logic sdi,
  output logic sdo
);
  logic [CNT_W-1:0]           cnt;
  logic                       exec;
  instr_t                     instr;
  logic                       wr_en;
  logic                       hit;
  logic [DATA_W-1:0]          rdata;
  logic [DATA_W-1:0]          echo;
  logic [NUM_REGS*DATA_W-1:0] bank_flat;
  logic [FRAME_W-1:0]         oframe;

  sreg_shifter u_shift (
    .sclk(sclk), .rst(rst), .sel_n(sel_n), .sdi(sdi),
    .cnt(cnt), .exec(exec), .instr(instr)
  );

  assign wr_en = exec && instr.op;

  sreg_bank #(.NUM_REGS(NUM_REGS), .BASE_ADDR(BASE_ADDR)) u_bank (
    .sclk(sclk), .rst(rst), .wr_en(wr_en), .addr(instr.addr),
    .wdata(instr.data), .hit(hit), .rdata(rdata), .echo(echo),
    .flat(bank_flat)
  );

  sreg_txframe u_tx (
    .sclk(sclk), .rst(rst), .sel_n(sel_n), .cnt(cnt), .load(exec),
    .op(instr.op), .addr(instr.addr), .data(echo),
    .oframe(oframe), .sdo(sdo)
  );
endmodule

// File: rtl/sreg_port_chk.sv
module sreg_port_chk
  import sreg_pkg::*;
#(
  parameter int NUM_REGS  = 8,
  parameter int BASE_ADDR = 1
) (
  input logic                       sclk,
  input logic                       rst,
  input logic                       sel_n,
  input logic [CNT_W-1:0]           cnt,
  input logic                       exec,
  input logic                       wr_en,
  input logic [ADDR_W-1:0]          addr,
  input logic [DATA_W-1:0]          rdata,
  input logic [NUM_REGS*DATA_W-1:0] bank_flat,
  input logic [FRAME_W-1:0]         oframe
);
  logic out_of_range;
  assign out_of_range = (int'(addr) < BASE_ADDR) || (int'(addr) >= BASE_ADDR + NUM_REGS);

  AST_CNT_BOUND: assert property (@(posedge sclk) disable iff (rst)
    cnt <= CNT_W'(FRAME_W + 1)); // R5
  AST_EXEC_AFTER_FULL: assert property (@(posedge sclk) disable iff (rst)
    exec |-> $past(cnt) == CNT_W'(FRAME_W - 1)); // R5
  AST_WR_AT_RELEASE: assert property (@(posedge sclk) disable iff (rst)
    wr_en |-> sel_n && $past(!sel_n)); // R3
  AST_BANK_QUIET: assert property (@(posedge sclk) disable iff (rst)
    !wr_en |=> $stable(bank_flat)); // R4
  AST_RESP_HOLD: assert property (@(posedge sclk) disable iff (rst)
    !sel_n |=> $stable(oframe)); // R6
  AST_UNMAPPED_ZERO: assert property (@(posedge sclk) disable iff (rst)
    out_of_range |-> rdata == '0); // R7
endmodule

bind sreg_port sreg_port_chk #(.NUM_REGS(NUM_REGS), .BASE_ADDR(BASE_ADDR)) u_chk (
  .sclk(sclk), .rst(rst), .sel_n(sel_n), .cnt(cnt), .exec(exec),
  .wr_en(wr_en), .addr(instr.addr), .rdata(rdata),
  .bank_flat(bank_flat), .oframe(oframe)
);

// File: tb/tb_sreg_port.sv
module tb_sreg_port;
  logic sclk = 1'b0;
  logic rst = 1'b1;
  logic sel_n = 1'b1;
  logic sdi = 1'b0;
  logic sdo;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  sreg_port dut (.sclk(sclk), .rst(rst), .sel_n(sel_n), .sdi(sdi), .sdo(sdo));

  always #10 sclk = ~sclk; // 50 MHz

  function automatic logic [40:0] mk(input logic op, input logic [6:0] a, input logic [31:0] d);
    logic [40:0] f;
    f = {d, a, op, 1'b0};
    f[0] = ^f[40:1];
    return f;
  endfunction

  task automatic chk(input string req, input logic [40:0] act, input logic [40:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Shift nbits of f; capture the response bits; verify sdo holds across rising edges (R9).
  task automatic xfer(input logic [40:0] f, input int nbits, output logic [40:0] got);
    logic held;
    held = 1'b1;
    got = '0;
    @(negedge sclk); #2;
    sel_n = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      if (i > 0) begin @(negedge sclk); #2; end
      if (i < 41) got[i] = sdo;
      sdi = (i < 41) ? f[i] : 1'b1;
      #7;
      if (sdo !== got[i < 41 ? i : 0] && i < 41) held = 1'b0;
      #2;
      if (sdo !== got[i < 41 ? i : 0] && i < 41) held = 1'b0;
    end
    @(negedge sclk); #2;
    sel_n = 1'b1;
    sdi = 1'b0;
    chk("R9", {40'd0, held}, 41'd1);
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d, output logic [40:0] got);
    xfer(mk(1'b1, a, d), 41, got);
  endtask

  // Read a then return the response shifted out during a following read of address 1.
  task automatic rd(input logic [6:0] a, output logic [40:0] resp);
    logic [40:0] tmp;
    xfer(mk(1'b0, a, 32'h0), 41, tmp);
    xfer(mk(1'b0, 7'd1, 32'h0), 41, resp);
  endtask

  task automatic t_reset();
    logic [40:0] r;
    chk("R1 sdo", {40'd0, sdo}, 41'd0);
    xfer(mk(1'b0, 7'd4, 32'h0), 41, r);
    chk("R1 first response", r, 41'd0);
    rd(7'd8, r);
    chk("R1 reg8", r, mk(1'b0, 7'd8, 32'h0));
  endtask

  task automatic t_write_read();
    logic [40:0] r;
    wr(7'd1, 32'hDEADBEEF, r);
    wr(7'd8, 32'h00000001, r);
    chk("R8 echo", r, mk(1'b1, 7'd1, 32'hDEADBEEF));
    wr(7'd5, 32'h80000000, r);
    chk("R2 lsb/msb echo", r, mk(1'b1, 7'd8, 32'h00000001));
    rd(7'd1, r);
    chk("R3 reg1", r, mk(1'b0, 7'd1, 32'hDEADBEEF));
    rd(7'd8, r);
    chk("R6 reg8", r, mk(1'b0, 7'd8, 32'h00000001));
    rd(7'd5, r);
    chk("R2 reg5", r, mk(1'b0, 7'd5, 32'h80000000));
  endtask

  task automatic t_bad_parity();
    logic [40:0] r, f;
    rd(7'd5, r);
    f = mk(1'b1, 7'd5, 32'h12345678);
    f[0] = ~f[0];
    xfer(f, 41, r);
    xfer(mk(1'b0, 7'd1, 32'h0), 41, r);
    chk("R4 response kept", r, mk(1'b0, 7'd1, 32'hDEADBEEF));
    rd(7'd5, r);
    chk("R4 reg5 kept", r, mk(1'b0, 7'd5, 32'h80000000));
  endtask

  task automatic t_bad_count();
    logic [40:0] r;
    rd(7'd3, r);
    xfer(mk(1'b1, 7'd3, 32'hA5A5A5A5), 40, r);
    xfer(mk(1'b1, 7'd3, 32'h5A5A5A5A), 42, r);
    chk("R5 response kept", r, mk(1'b0, 7'd1, 32'hDEADBEEF));
    rd(7'd3, r);
    chk("R5 reg3 kept", r, mk(1'b0, 7'd3, 32'h0));
  endtask

  task automatic t_unmapped();
    logic [40:0] r;
    wr(7'd0, 32'hFFFFFFFF, r);
    wr(7'd9, 32'hCAFEF00D, r);
    chk("R7 addr0 echo", r, mk(1'b1, 7'd0, 32'h0));
    wr(7'd127, 32'h0BADC0DE, r);
    chk("R7 addr9 echo", r, mk(1'b1, 7'd9, 32'h0));
    rd(7'd127, r);
    chk("R7 addr127 read", r, mk(1'b0, 7'd127, 32'h0));
    rd(7'd8, r);
    chk("R7 reg8 intact", r, mk(1'b0, 7'd8, 32'h00000001));
  endtask

  initial begin
    repeat (3) @(posedge sclk);
    @(negedge sclk); #2;
    rst = 1'b0;
    @(negedge sclk); #2;
    t_reset();
    t_write_read();
    t_bad_parity();
    t_bad_count();
    t_unmapped();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge sclk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule